// File: doc/BRIEF.md
# Shared Reset Pin Sequencer

This block owns an open-drain, active-low reset pin. Several internal reset sources and any external device on the board can use the same pin. The block runs on its own self-reset clock. When an internal source requests a reset, or when the pin is seen low while the block is idle, it does three things in order:

1. It asserts the system reset.
2. It pulls the pin low for a fixed drive phase.
3. It releases the pin and waits a fixed settle phase.

At the end of the settle phase it looks at the synchronized pin level. A pin that is still low means an external device is holding reset, so the cause is recorded as external and the sequence starts again with the system reset still asserted. A pin that is high means the cause is recorded as internal, the system reset is released, and the mode-select input is captured on that same edge.

The raw pin goes through a multi-flop synchronizer. A low pulse that spans at least one sampling edge is enough to start a sequence. Any internal request that arrives during the drive or settle phase restarts the sequence from the beginning.

Top module: `rst_pin_ctrl`

## Requirements
- R1: While `rst_ni` is low, the outputs are as follows: `pin_drive_o`=1, `sys_rst_o`=1, both cause flags 0 and `mode_o`=0. After `rst_ni` rises, the block runs one full sequence starting from the drive phase.
- R2: Each sequence holds `pin_drive_o` high for exactly `DRIVE_CYC` (default 34) consecutive clock cycles.
- R3: After the drive phase, `sys_rst_o` stays high with `pin_drive_o` low for exactly `WAIT_CYC` (default 38) cycles. The sampling edge ends that phase.
- R4: On the sampling edge, the flags are set from the synchronized pin. A low pin gives `cause_ext_o`=1 and `cause_int_o`=0. A high pin gives the reverse. The two flags are never both high.
- R5: The cause flags and `mode_o` change only on a sampling edge. They hold their values at every other time, whatever `mode_i` or the pin does.
- R6: An internal request during the drive or settle phase restarts the drive phase. From the cycle after the request, `DRIVE_CYC` drive cycles follow, then `WAIT_CYC` settle cycles.
- R7: While the block is idle, an external low pulse of at least 1.5 clock periods starts a sequence. `pin_drive_o` rises no more than 3 clock edges after the pulse starts.
- R8: `mode_o` takes the level `mode_i` has on the edge that releases `sys_rst_o`.
- R9: Any single bit of `int_req_i` starts a sequence from idle.
- R10: If the pin is still low on the sampling edge, `sys_rst_o` stays asserted and a new drive phase begins on that edge. `sys_rst_o` deasserts only after a sample that sees the pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Self-reset clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| int_req_i | input | N_SRC | Internal reset requests, one bit per source |
| pin_i | input | 1 | Raw level of the shared reset pin |
| mode_i | input | 1 | Mode-select pin, captured when reset is released |
| pin_drive_o | output | 1 | 1 = pull the reset pin low |
| sys_rst_o | output | 1 | System reset, active high |
| cause_ext_o | output | 1 | Sticky flag: last reset came from an external source |
| cause_int_o | output | 1 | Sticky flag: last reset came from an internal source |
| mode_o | output | 1 | Mode-select value captured at reset release |

## Verification
Two events can fall on the same edge: the sampling decision that ends the settle phase, and a restart, caused either by an internal request or by the pin still being held low. The bench provokes both:

- It holds the pin low externally across the first sampling edge. It checks that the external flag appears on exactly that edge while `sys_rst_o` never drops, and that a second full sequence follows with an internal classification.
- It injects restarts part-way through the drive phase and part-way through the settle phase. In each case it measures that the full phase lengths follow the request.

Phase lengths are counted at the ports and compared with `DRIVE_CYC` and `WAIT_CYC`.

// File: rtl/rpc_pkg.sv
`timescale 1ns/1ps
package rpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2
  } rpc_state_e;
endpackage

// File: rtl/rpc_sync.sv
`timescale 1ns/1ps
module rpc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rpc_ext_detect.sv
`timescale 1ns/1ps
module rpc_ext_detect #(
  parameter int EXT_LOW_MIN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  output logic hit_o
);
  localparam int LOW_W = $clog2(EXT_LOW_MIN + 1);
  localparam logic [LOW_W-1:0] RUN_SAT = LOW_W'(EXT_LOW_MIN);

  logic [LOW_W-1:0] run_q;
  logic [LOW_W:0]   run_next;

  assign run_next = {1'b0, run_q} + 1'b1;
  // the current low sample counts toward the run
  assign hit_o = !pin_s_i && (run_next >= {1'b0, RUN_SAT});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (pin_s_i)       run_q <= '0;
    else if (run_q < RUN_SAT) run_q <= run_next[LOW_W-1:0];
  end

  AST_RUN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_SAT); // R7
  AST_HIGH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_s_i |=> (run_q == '0)); // R7
endmodule

// File: rtl/rpc_seq.sv
`timescale 1ns/1ps
module rpc_seq
  import rpc_pkg::*;
#(
  parameter int DRIVE_CYC = 34,
  parameter int WAIT_CYC  = 38
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic restart_i,
  input  logic pin_s_i,
  input  logic mode_i,
  output logic drive_o,
  output logic sys_rst_o,
  output logic cause_ext_o,
  output logic cause_int_o,
  output logic mode_o
);
  localparam int MAX_CYC = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] WT_LAST  = CNT_W'(WAIT_CYC - 1);

  rpc_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cause_ext_q, cause_int_q, mode_q;
  logic             sample_now;

  assign sample_now = (st_q == ST_WAIT) && (cnt_q == WT_LAST) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_DRIVE;
      cnt_q       <= '0;
      cause_ext_q <= 1'b0;
      cause_int_q <= 1'b0;
      mode_q      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q  <= ST_DRIVE;
            cnt_q <= '0;
          end
        end
        ST_DRIVE: begin
          if (restart_i) begin
            cnt_q <= '0;
          end else if (cnt_q == DRV_LAST) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (restart_i) begin
            st_q  <= ST_DRIVE;
            cnt_q <= '0;
          end else if (cnt_q == WT_LAST) begin
            cause_ext_q <= !pin_s_i;
            cause_int_q <= pin_s_i;
            cnt_q       <= '0;
            if (pin_s_i) begin
              st_q   <= ST_IDLE;
              mode_q <= mode_i;
            end else begin
              // pin still held: keep reset, drive again
              st_q <= ST_DRIVE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_DRIVE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign drive_o     = (st_q == ST_DRIVE);
  assign sys_rst_o   = (st_q != ST_IDLE);
  assign cause_ext_o = cause_ext_q;
  assign cause_int_o = cause_int_q;
  assign mode_o      = mode_q;

  AST_DRIVE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRIVE) |-> (cnt_q <= DRV_LAST)); // R2
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> (cnt_q <= WT_LAST)); // R3
  AST_CAUSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cause_ext_q, cause_int_q})); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_now |=> $stable({cause_ext_q, cause_int_q, mode_q})); // R5
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q != ST_IDLE) && restart_i) |=> ((st_q == ST_DRIVE) && (cnt_q == '0))); // R6
  AST_RELEASE_PIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (cause_int_q && !cause_ext_q)); // R10
endmodule

// File: rtl/rst_pin_ctrl.sv
`timescale 1ns/1ps
module rst_pin_ctrl #(
  parameter int N_SRC       = 4,
  parameter int DRIVE_CYC   = 34,
  parameter int WAIT_CYC    = 38,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_LOW_MIN = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] int_req_i,
  input  logic             pin_i,
  input  logic             mode_i,
  output logic             pin_drive_o,
  output logic             sys_rst_o,
  output logic             cause_ext_o,
  output logic             cause_int_o,
  output logic             mode_o
);
  logic pin_s, ext_hit, any_int;

  assign any_int = |int_req_i;

  rpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  rpc_ext_detect #(.EXT_LOW_MIN(EXT_LOW_MIN)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_s_i(pin_s),
    .hit_o  (ext_hit)
  );

  rpc_seq #(.DRIVE_CYC(DRIVE_CYC), .WAIT_CYC(WAIT_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (any_int | ext_hit),
    .restart_i  (any_int),
    .pin_s_i    (pin_s),
    .mode_i     (mode_i),
    .drive_o    (pin_drive_o),
    .sys_rst_o  (sys_rst_o),
    .cause_ext_o(cause_ext_o),
    .cause_int_o(cause_int_o),
    .mode_o     (mode_o)
  );

  AST_EXT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && ext_hit) |=> pin_drive_o); // R7
  AST_INT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && any_int) |=> (pin_drive_o && sys_rst_o)); // R9
  AST_DRIVE_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_drive_o) |-> sys_rst_o); // R2
endmodule

// File: tb/rst_pin_ctrl_bench.sv
`timescale 1ns/1ps
module rst_pin_ctrl_bench;
  localparam int N_SRC = 4;
  localparam int DRV   = 34;
  localparam int WT    = 38;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_SRC-1:0] int_req = '0;
  logic             ext_hold = 1'b0;
  logic             mode_in = 1'b0;
  logic             pin, drive, sys_rst, c_ext, c_int, mode_out;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  // wired-AND pin: pulled up, low if either side drives
  assign pin = ~(drive | ext_hold);

  rst_pin_ctrl #(.N_SRC(N_SRC), .DRIVE_CYC(DRV), .WAIT_CYC(WT)) u_rst_pin_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .int_req_i  (int_req),
    .pin_i      (pin),
    .mode_i     (mode_in),
    .pin_drive_o(drive),
    .sys_rst_o  (sys_rst),
    .cause_ext_o(c_ext),
    .cause_int_o(c_int),
    .mode_o     (mode_out)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts drive cycles then settle cycles, starting at the current negedge
  task automatic measure(output int nd, output int nw);
    nd = 0; nw = 0;
    while (drive && nd < 500) begin nd++; @(negedge clk); end
    while (sys_rst && !drive && nw < 500) begin nw++; @(negedge clk); end
  endtask

  task automatic pulse_int(input logic [N_SRC-1:0] bits);
    int_req = bits;
    @(negedge clk);
    int_req = '0;
  endtask

  task automatic wait_drive(output int lat);
    lat = 0;
    while (!drive && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic check_release(input string tag, input int nd, input int nw,
                               input logic m);
    chk(nd == DRV, {tag, " R2 drive len"}, nd, DRV);
    chk(nw == WT, {tag, " R3 settle len"}, nw, WT);
    chk(!sys_rst, {tag, " R3 reset released"}, int'(sys_rst), 0);
    chk(c_int && !c_ext, {tag, " R4 internal cause"}, {c_ext, c_int}, 1);
    chk(mode_out == m, {tag, " R8 mode latched"}, int'(mode_out), int'(m));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int nd, nw, lat;
    logic ok_rst;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(drive && sys_rst, "R1 drive/reset in POR", {drive, sys_rst}, 3);
    chk(!c_ext && !c_int && !mode_out, "R1 flags/mode clear", {c_ext, c_int, mode_out}, 0);
    rst_n = 1'b1;
    measure(nd, nw);
    check_release("R1 por", nd, nw, 1'b0);

    // R9/R8 sweep over every source bit and both mode levels
    for (int b = 0; b < N_SRC; b++) begin
      for (int m = 0; m < 2; m++) begin
        mode_in = m[0];
        repeat (2) @(negedge clk);
        pulse_int(N_SRC'(1) << b);
        chk(drive && sys_rst, $sformatf("R9 src%0d starts", b), int'(drive), 1);
        measure(nd, nw);
        check_release($sformatf("R9 src%0d m%0d", b, m), nd, nw, m[0]);
        // R5 mode pin changes while idle do not move mode_o
        mode_in = ~m[0];
        repeat (3) @(negedge clk);
        chk(mode_out == m[0], "R5 mode held in idle", int'(mode_out), m);
      end
    end

    // R6 restart in drive phase, with R5 mode change mid-sequence
    mode_in = 1'b0;
    @(negedge clk);
    pulse_int(4'b0001);
    repeat (20) @(negedge clk);
    mode_in = 1'b1;
    @(negedge clk);
    chk(mode_out == 1'b1, "R5 mode held in sequence", int'(mode_out), 1);
    mode_in = 1'b0;
    pulse_int(4'b0100);
    measure(nd, nw);
    check_release("R6 drive restart", nd, nw, 1'b0);

    // R6 restart in settle phase
    @(negedge clk);
    pulse_int(4'b0010);
    repeat (DRV + 10) @(negedge clk);
    chk(sys_rst && !drive, "R6 in settle before restart", int'(drive), 0);
    pulse_int(4'b1000);
    measure(nd, nw);
    check_release("R6 settle restart", nd, nw, 1'b0);

    // R7 short pulse aligned to a falling edge
    repeat (4) @(negedge clk);
    ext_hold = 1'b1; #8; ext_hold = 1'b0;
    @(negedge clk);
    wait_drive(lat);
    chk(lat <= 2, "R7 short pulse A caught", lat, 2);
    measure(nd, nw);
    check_release("R7 pulse A", nd, nw, 1'b0);

    // R7 short pulse just after a rising edge
    repeat (4) @(negedge clk);
    @(posedge clk); #0.5; ext_hold = 1'b1; #7.5; ext_hold = 1'b0;
    @(negedge clk);
    wait_drive(lat);
    chk(lat <= 2, "R7 short pulse B caught", lat, 2);
    measure(nd, nw);
    check_release("R7 pulse B", nd, nw, 1'b0);

    // R10 pin held externally across the first sampling edge
    repeat (4) @(negedge clk);
    ext_hold = 1'b1;
    @(negedge clk);
    lat = 1;
    while (!drive && lat < 20) begin @(negedge clk); lat++; end
    chk(lat == 3, "R7 held pin latency", lat, 3);
    ok_rst = 1'b1;
    for (int k = 0; k < DRV + WT; k++) begin
      ok_rst &= sys_rst;
      @(negedge clk);
    end
    chk(ok_rst && sys_rst, "R10 reset never dropped", int'(ok_rst), 1);
    chk(c_ext && !c_int, "R10 R4 external cause", {c_ext, c_int}, 2);
    chk(drive, "R10 drive restarted", int'(drive), 1);
    ext_hold = 1'b0;
    measure(nd, nw);
    check_release("R10 second pass", nd, nw, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule